// File: doc/BRIEF.md
# Tagged Floating-Point Register Stack

This block holds eight 80-bit floating-point registers. Software addresses them as a stack, relative to a 3-bit top pointer. Every physical register carries a 2-bit tag that records whether it is empty or what kind of value it holds. A push moves the top pointer down by one and then writes the incoming value, and the tag of that value is worked out from its exponent and significand fields. A pop empties the register at the top and then moves the pointer up. Any stack slot ST(i) can be read in the same cycle at physical register (TOP + i) mod 8.

Pushes and pops are checked against the tags. Pushing into a register that is still occupied is an overflow. Popping an empty top is an underflow. Either one raises a stack fault and an invalid-operation flag, and the C1 output reports the direction. A faulting request leaves the pointer, the tags and the data unchanged. An initialise command empties the whole stack and clears the flags. A store-then-pop is done by reading ST(0) and asserting pop in the same cycle.

Top module: `fpstk_regstack`

## Requirements
- R1: After reset, and after an initialise command, the top pointer is 0, every tag is 11 (tag word 0xFFFF), and the stack fault, C1 and invalid outputs are 0.
- R2: A successful push moves the top pointer to (TOP - 1) mod 8 and writes the value into that register. The first push after initialise therefore lands in R7.
- R3: A pushed value is tagged from bit fields exponent [78:64] and significand [63:0]. Exponent all ones gives 10 (special). Exponent zero with a zero significand gives 01 (zero). Exponent zero with a non-zero significand gives 10. Anything else gives 00 (valid).
- R4: The tag word holds the tag of physical register k in bits [2k+1:2k]. Pushing a valid value into an empty stack gives 0x3FFF, and pushing a zero after that gives 0x1FFF.
- R5: The read data is, combinationally, the content of physical register (TOP + read index) mod 8.
- R6: A successful pop sets the tag of the register at TOP to 11 and then moves the top pointer to (TOP + 1) mod 8.
- R7: A push whose target register (TOP - 1) is not empty sets stack fault, C1=1 and invalid, and leaves TOP, the tags and the register data unchanged.
- R8: A pop while the register at TOP is empty sets stack fault, C1=0 and invalid, and leaves TOP and the tags unchanged.
- R9: Stack fault and invalid stay set through later successful operations until an initialise command. C1 holds the direction of the most recent fault.
- R10: Initialise takes priority over push and pop. A push and a pop requested together act as the push alone.
- R11: The top pointer wraps modulo 8 in both directions, so eight pushes followed by eight pops return the pointer to its starting value with all tags empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Empty the stack and clear flags |
| push_i | input | 1 | Push push_data_i |
| pop_i | input | 1 | Pop ST(0) |
| push_data_i | input | 80 | Value to push |
| rd_idx_i | input | 3 | Relative index i of ST(i) |
| rd_data_o | output | 80 | Contents of ST(i) |
| top_o | output | 3 | Current top pointer |
| tag_word_o | output | 16 | Packed tags, two bits per physical register |
| stack_fault_o | output | 1 | Sticky stack fault flag |
| c1_o | output | 1 | Fault direction: 1 overflow, 0 underflow |
| invalid_o | output | 1 | Sticky invalid-operation flag |

## Verification
The overflow case is the hardest to reach from the ports. It needs eight successful pushes in a row with no pop in between, so that the pointer comes around to an occupied register. The stimulus fills the stack with a mix of valid, zero, special and denormal values, pushes one more, and then reads back every slot to show that nothing moved. The pointer wrap is reached the same way, with eight pushes and then eight pops, and a ninth pop confirms the underflow.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;
  typedef enum logic [1:0] {
    TAG_VALID   = 2'b00,
    TAG_ZERO    = 2'b01,
    TAG_SPECIAL = 2'b10,
    TAG_EMPTY   = 2'b11
  } tag_t;
endpackage

// File: rtl/fpstk_classify.sv
module fpstk_classify
  import fpstk_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64
) (
  input  logic [EXP_W-1:0] exp_i,
  input  logic [MAN_W-1:0] man_i,
  output tag_t             tag_o
);
  logic exp_max, exp_zero, man_zero;

  assign exp_max  = &exp_i;
  assign exp_zero = ~|exp_i;
  assign man_zero = ~|man_i;

  always_comb begin
    if (exp_max)                   tag_o = TAG_SPECIAL;
    else if (exp_zero && man_zero) tag_o = TAG_ZERO;
    else if (exp_zero)             tag_o = TAG_SPECIAL; // denormal
    else                           tag_o = TAG_VALID;
  end
endmodule

// File: rtl/fpstk_regfile.sv
module fpstk_regfile #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 80,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] regs [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 regs[g] <= '0;
      else if (wr_en_i && wr_addr_i == AW'(g))     regs[g] <= wr_data_i;
    end
  end

  assign rd_data_o = regs[rd_addr_i];
endmodule

// File: rtl/fpstk_ctrl.sv
module fpstk_ctrl
  import fpstk_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int TW   = 2 * DEPTH
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  tag_t          push_tag_i,
  input  logic [AW-1:0] rd_idx_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [AW-1:0] rd_addr_o,
  output logic [AW-1:0] top_o,
  output logic [TW-1:0] tag_word_o,
  output logic          stack_fault_o,
  output logic          c1_o,
  output logic          invalid_o
);
  logic [AW-1:0] top_q;
  tag_t          tag_q [DEPTH];
  logic          sf_q, c1_q, inv_q;

  logic [AW-1:0] push_slot;
  logic          do_push, do_pop, push_ok, pop_ok;

  // priority: init > push > pop
  assign push_slot = AW'(top_q - AW'(1));
  assign do_push   = push_i && !init_i;
  assign do_pop    = pop_i && !push_i && !init_i;
  assign push_ok   = do_push && (tag_q[push_slot] == TAG_EMPTY);
  assign pop_ok    = do_pop && (tag_q[top_q] != TAG_EMPTY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      top_q <= '0;
      sf_q  <= 1'b0;
      c1_q  <= 1'b0;
      inv_q <= 1'b0;
    end else if (init_i) begin
      top_q <= '0;
      sf_q  <= 1'b0;
      c1_q  <= 1'b0;
      inv_q <= 1'b0;
    end else if (do_push) begin
      if (push_ok) top_q <= push_slot;
      else begin
        sf_q  <= 1'b1;
        c1_q  <= 1'b1;
        inv_q <= 1'b1;
      end
    end else if (do_pop) begin
      if (pop_ok) top_q <= AW'(top_q + AW'(1));
      else begin
        sf_q  <= 1'b1;
        c1_q  <= 1'b0;
        inv_q <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_tag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                tag_q[g] <= TAG_EMPTY;
      else if (init_i)                            tag_q[g] <= TAG_EMPTY;
      else if (push_ok && push_slot == AW'(g))    tag_q[g] <= push_tag_i;
      else if (pop_ok && top_q == AW'(g))         tag_q[g] <= TAG_EMPTY;
    end
    assign tag_word_o[2*g +: 2] = tag_q[g];
  end

  assign wr_en_o       = push_ok;
  assign wr_addr_o     = push_slot;
  assign rd_addr_o     = AW'(top_q + rd_idx_i);
  assign top_o         = top_q;
  assign stack_fault_o = sf_q;
  assign c1_o          = c1_q;
  assign invalid_o     = inv_q;
endmodule

// File: rtl/fpstk_regstack.sv
module fpstk_regstack
  import fpstk_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int EXP_W  = 15,
  parameter int MAN_W  = 64,
  localparam int DATA_W = 1 + EXP_W + MAN_W,
  localparam int AW     = $clog2(DEPTH),
  localparam int TW     = 2 * DEPTH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic [AW-1:0]     rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [AW-1:0]     top_o,
  output logic [TW-1:0]     tag_word_o,
  output logic              stack_fault_o,
  output logic              c1_o,
  output logic              invalid_o
);
  tag_t          push_tag;
  logic          wr_en;
  logic [AW-1:0] wr_addr, rd_addr;

  fpstk_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_classify (
    .exp_i (push_data_i[MAN_W +: EXP_W]),
    .man_i (push_data_i[MAN_W-1:0]),
    .tag_o (push_tag)
  );

  fpstk_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .init_i        (init_i),
    .push_i        (push_i),
    .pop_i         (pop_i),
    .push_tag_i    (push_tag),
    .rd_idx_i      (rd_idx_i),
    .wr_en_o       (wr_en),
    .wr_addr_o     (wr_addr),
    .rd_addr_o     (rd_addr),
    .top_o         (top_o),
    .tag_word_o    (tag_word_o),
    .stack_fault_o (stack_fault_o),
    .c1_o          (c1_o),
    .invalid_o     (invalid_o)
  );

  fpstk_regfile #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_regfile (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (push_data_i),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/fpstk_regstack_chk.sv
module fpstk_regstack_chk #(
  parameter int AW = 3,
  parameter int TW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          init_i,
  input logic          push_i,
  input logic          pop_i,
  input logic [AW-1:0] top_o,
  input logic [TW-1:0] tag_word_o,
  input logic          stack_fault_o,
  input logic          c1_o,
  input logic          invalid_o
);
  function automatic logic [1:0] tag_at(input logic [TW-1:0] tw, input logic [AW-1:0] i);
    return tw[2*i +: 2];
  endfunction

  assert_init_clears_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (tag_word_o == '1) && (top_o == '0) && !stack_fault_o && !invalid_o && !c1_o);

  assert_push_moves_top_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !init_i && tag_at(tag_word_o, AW'(top_o - AW'(1))) == 2'b11)
    |=> (top_o == AW'($past(top_o) - AW'(1))) && (tag_at(tag_word_o, top_o) != 2'b11));

  assert_pop_empties_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !init_i && tag_at(tag_word_o, top_o) != 2'b11)
    |=> (top_o == AW'($past(top_o) + AW'(1))) && (tag_at(tag_word_o, $past(top_o)) == 2'b11));

  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !init_i && tag_at(tag_word_o, AW'(top_o - AW'(1))) != 2'b11)
    |=> stack_fault_o && c1_o && invalid_o && $stable(top_o) && $stable(tag_word_o));

  assert_no_underflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !init_i && tag_at(tag_word_o, top_o) == 2'b11)
    |=> stack_fault_o && !c1_o && invalid_o && $stable(top_o) && $stable(tag_word_o));

  assert_flags_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stack_fault_o && invalid_o && !init_i) |=> stack_fault_o && invalid_o);
endmodule

bind fpstk_regstack fpstk_regstack_chk #(.AW(AW), .TW(TW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .init_i        (init_i),
  .push_i        (push_i),
  .pop_i         (pop_i),
  .top_o         (top_o),
  .tag_word_o    (tag_word_o),
  .stack_fault_o (stack_fault_o),
  .c1_o          (c1_o),
  .invalid_o     (invalid_o)
);

// File: tb/fpstk_regstack_bench.sv
`timescale 1ns/1ps
module fpstk_regstack_bench;
  typedef struct packed {
    logic [2:0]  top;
    logic [15:0] tw;
    logic        sf, c1, inv;
  } snap_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init = 1'b0, push = 1'b0, pop = 1'b0;
  logic [79:0] pdata = '0;
  logic [2:0]  rd_idx = '0;
  logic [79:0] rd_data;
  logic [2:0]  top;
  logic [15:0] tw;
  logic        sf, c1, inv;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // model
  logic [2:0]  m_top;
  logic [1:0]  m_tag [8];
  logic [79:0] m_dat [8];
  logic        m_sf, m_c1, m_inv;

  snap_t exp_q[$];
  string req_q[$];

  localparam logic [79:0] V_ONE  = {1'b0, 15'h3fff, 64'h8000_0000_0000_0000};
  localparam logic [79:0] V_ZERO = '0;
  localparam logic [79:0] V_INF  = {1'b0, 15'h7fff, 64'h8000_0000_0000_0000};
  localparam logic [79:0] V_DEN  = {1'b0, 15'h0000, 64'h0000_0000_0000_0001};
  localparam logic [79:0] V_NTWO = {1'b1, 15'h4000, 64'h8000_0000_0000_0000};

  always #4 clk = ~clk;

  fpstk_regstack u_fpstk_regstack (
    .clk_i(clk), .rst_ni(rst_n), .init_i(init), .push_i(push), .pop_i(pop),
    .push_data_i(pdata), .rd_idx_i(rd_idx), .rd_data_o(rd_data), .top_o(top),
    .tag_word_o(tw), .stack_fault_o(sf), .c1_o(c1), .invalid_o(inv)
  );

  function automatic logic [1:0] ref_tag(input logic [79:0] d);
    if (d[78:64] == 15'h7fff) return 2'b10;
    if (d[78:64] == 15'h0000) return (d[63:0] == 64'd0) ? 2'b01 : 2'b10;
    return 2'b00;
  endfunction

  function automatic logic [15:0] m_tw();
    logic [15:0] w;
    for (int k = 0; k < 8; k++) w[2*k +: 2] = m_tag[k];
    return w;
  endfunction

  task automatic chk(input string req, input logic [79:0] act, input logic [79:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic model_init();
    m_top = 3'd0; m_sf = 1'b0; m_c1 = 1'b0; m_inv = 1'b0;
    for (int k = 0; k < 8; k++) m_tag[k] = 2'b11;
  endtask

  // driver: applies one request, updates the model, queues the expected state
  task automatic op(input logic i, input logic p, input logic q,
                    input logic [79:0] d, input string req);
    logic [2:0] slot;
    @(negedge clk);
    init = i; push = p; pop = q; pdata = d;
    @(posedge clk);
    if (i) model_init();
    else if (p) begin
      slot = m_top - 3'd1;
      if (m_tag[slot] == 2'b11) begin
        m_top = slot; m_tag[slot] = ref_tag(d); m_dat[slot] = d;
      end else begin
        m_sf = 1'b1; m_c1 = 1'b1; m_inv = 1'b1;
      end
    end else if (q) begin
      if (m_tag[m_top] == 2'b11) begin
        m_sf = 1'b1; m_c1 = 1'b0; m_inv = 1'b1;
      end else begin
        m_tag[m_top] = 2'b11; m_top = m_top + 3'd1;
      end
    end
    exp_q.push_back('{top: m_top, tw: m_tw(), sf: m_sf, c1: m_c1, inv: m_inv});
    req_q.push_back(req);
    #1 init = 1'b0; push = 1'b0; pop = 1'b0;
  endtask

  task automatic rdchk(input logic [2:0] idx, input string req);
    @(negedge clk);
    #1 rd_idx = idx;
    #1 chk(req, rd_data, m_dat[3'(m_top + idx)]);
  endtask

  // monitor: compares the queued expectation one half cycle after each request edge
  initial begin
    snap_t e;
    string r;
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        r = req_q.pop_front();
        chk({r, " top"},  80'(top), 80'(e.top));
        chk({r, " tags"}, 80'(tw),  80'(e.tw));
        chk({r, " flags"}, 80'({sf, c1, inv}), 80'({e.sf, e.c1, e.inv}));
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    model_init();
    for (int k = 0; k < 8; k++) m_dat[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset tags", 80'(tw), 80'(16'hffff));
    chk("R1 reset top/flags", 80'({top, sf, c1, inv}), 80'(0));

    op(0, 1, 0, V_ONE,  "R2 R4 first push to R7");
    chk("R4 tag word 0x3FFF", 80'(16'h3fff), 80'(m_tw()));
    op(0, 1, 0, V_ZERO, "R3 R4 zero push");
    chk("R4 tag word 0x1FFF", 80'(16'h1fff), 80'(m_tw()));
    op(0, 1, 0, V_INF,  "R3 infinity special");
    op(0, 1, 0, V_DEN,  "R3 denormal special");
    op(0, 1, 0, V_NTWO, "R3 negative valid");
    rdchk(3'd0, "R5 read ST0");
    rdchk(3'd1, "R5 read ST1");
    rdchk(3'd3, "R5 read ST3");
    rdchk(3'd4, "R5 read ST4");
    // fill to full, then overflow
    op(0, 1, 0, {1'b0, 15'h4001, 64'hc000_0000_0000_0000}, "R2 fill");
    op(0, 1, 0, {1'b0, 15'h3ffe, 64'h8000_0000_0000_0001}, "R2 fill");
    op(0, 1, 0, {1'b0, 15'h0001, 64'h8000_0000_0000_0000}, "R2 fill");
    op(0, 1, 0, {1'b1, 15'h1234, 64'hffff_0000_ffff_0000}, "R7 overflow push");
    for (int k = 0; k < 8; k++) rdchk(3'(k), "R7 data kept after overflow");
    op(0, 0, 1, '0, "R6 R9 pop keeps sticky flags");
    op(0, 1, 0, V_ZERO, "R9 push after fault");
    // init wins over push
    op(1, 1, 0, V_ONE, "R10 R1 init beats push");
    // underflow on empty
    op(0, 0, 1, '0, "R8 underflow pop");
    op(1, 0, 0, '0, "R1 init clears flags");
    // push and pop together: push only
    op(0, 1, 1, V_INF, "R10 push beats pop");
    rdchk(3'd0, "R10 pushed value visible");
    op(0, 0, 1, '0, "R6 pop last");
    // wrap: eight pushes then eight pops
    for (int k = 0; k < 8; k++)
      op(0, 1, 0, {1'b0, 15'(16'h3ff0 + k), 64'h8000_0000_0000_0000 | 64'(k)}, "R11 wrap push");
    rdchk(3'd7, "R11 R5 read ST7");
    for (int k = 0; k < 8; k++) op(0, 0, 1, '0, "R11 R6 wrap pop");
    op(0, 0, 1, '0, "R8 R11 ninth pop underflow");
    op(0, 1, 0, V_ONE, "R9 C1 follows last fault");
    op(0, 1, 0, V_ZERO, "R2 push after wrap");
    op(0, 0, 1, '0, "R6 pop after wrap");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule